// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits in the execute stage of a processor that shares its instruction stream with one or more coprocessors that watch the instruction bus. When an instruction bound for a coprocessor reaches execute, the sequencer decides whether to offer it, raises a request line towards every coprocessor, and reads back two shared response lines, one saying that no coprocessor claims the instruction and one saying that the claiming coprocessor is not yet ready. From these it picks one of four results: drop the instruction silently, raise the undefined-instruction trap, hold the pipeline in a busy-wait, or commit.

A committed transfer instruction turns into a word-address stream. The sequencer starts at the supplied address, steps by one word every cycle and stops when the coprocessor reports that the transfer is over, or when a fixed word limit is reached. Interrupts may end a busy-wait. They have no effect once a transfer has begun.

The response lines are sampled only on clock edges. Nothing in this block feeds the request line back into them combinationally, so a coprocessor must produce both responses on its own.

Top module: `cop_handshake_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cop_req`, `stall`, `undef_trap`, `irq_take`, `xfer_active` and `retire` are all 0.
- R2: An instruction presented with `cond_pass`=0 or `in_shadow`=1 is dropped: `cop_req` never rises and no trap, stall, retire or interrupt pulse follows.
- R3: An accepted instruction (`instr_valid`=1, `cond_pass`=1, `in_shadow`=0) raises `cop_req` in the next cycle. `cop_req` stays high through the decision cycle and every busy-wait cycle.
- R4: If `cop_absent` is sampled 1 while `cop_req` is high, `undef_trap` is a one-cycle pulse in the next cycle, `cop_req` falls, and the block returns to idle.
- R5: If `cop_absent`=0 and `cop_busy`=1 are sampled while `cop_req` is high and no interrupt ends the wait, `stall` is 1 in the next cycle. It stays 1 for as many cycles as `cop_busy` is sampled high in the wait.
- R6: If `cop_absent`=0 and `cop_busy`=0 are sampled while `cop_req` is high, the instruction commits. A non-transfer instruction gives a one-cycle `retire` pulse in the next cycle. A transfer instruction starts its address stream in the next cycle.
- R7: If `irq` is sampled 1 during a busy-wait cycle in which `cop_busy` is still 1 and `cop_absent` is 0, the instruction is abandoned. `irq_take` pulses for one cycle in the next cycle, `cop_req` and `stall` are 0 in that cycle, and no `retire` follows.
- R8: During a transfer `xfer_active` is 1. `addr` equals `start_addr` (captured when the instruction was accepted) in the first transfer cycle and grows by 4 in each later transfer cycle.
- R9: During a transfer, `cop_absent`=1 together with `cop_busy`=1 marks the current word as the last one. The next cycle has `xfer_active`=0 and a one-cycle `retire` pulse. Any other response pair lets the transfer continue.
- R10: A transfer never lasts more than 16 words. After the 16th word the transfer ends with `retire`, even if the coprocessor has not signalled the end.
- R11: `irq` has no effect during a transfer: `irq_take` stays 0 and the word count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A coprocessor instruction is at execute this cycle |
| is_xfer | input | 1 | That instruction is a memory transfer |
| cond_pass | input | 1 | The instruction passed its condition test |
| in_shadow | input | 1 | The instruction lies in a branch shadow |
| irq | input | 1 | Enabled interrupt request |
| start_addr | input | ADDR_W | First word address of a transfer |
| cop_absent | input | 1 | Shared response: no coprocessor claims the instruction |
| cop_busy | input | 1 | Shared response: the claiming coprocessor is not ready |
| cop_req | output | 1 | Request to all coprocessors to execute the instruction |
| stall | output | 1 | Pipeline held in busy-wait |
| undef_trap | output | 1 | One-cycle undefined-instruction trap |
| irq_take | output | 1 | One-cycle pulse: busy-wait abandoned for the interrupt |
| retire | output | 1 | One-cycle pulse: committed instruction completed |
| xfer_active | output | 1 | Transfer address stream is running |
| addr | output | ADDR_W | Current transfer word address |

## Verification
The bench covers both ways an instruction can be dropped. A faulty design here would raise the request or retire a shadowed instruction. It checks the exact length of the busy-wait, since an off-by-one in the response sampling shows up as one stall cycle too many or too few. It raises an interrupt during a busy-wait; a design that ignored it would stall forever or retire the instruction. It also holds the interrupt through a whole transfer, which a design that wrongly honoured it would cut short. Transfers are ended by the coprocessor after three words and by the sixteen-word cap. Each word address is compared, so a design that loses the start address, steps by the wrong amount or runs past the cap is caught.

// File: rtl/cop_hs_pkg.sv
package cop_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DECIDE    = 3'd1,
        ST_BUSY_WAIT = 3'd2,
        ST_XFER      = 3'd3,
        ST_TRAP      = 3'd4,
        ST_DONE      = 3'd5
    } hs_state_e;

    typedef enum logic [1:0] {
        RSP_TAKE   = 2'd0,
        RSP_WAIT   = 2'd1,
        RSP_ABSENT = 2'd2
    } hs_resp_e;

    typedef struct packed {
        logic valid;
        logic cond_ok;
        logic shadow;
    } hs_issue_t;

    // Classify the shared response lines during the handshake.
    // An absent report wins over busy.
    function automatic hs_resp_e classify(input logic absent, input logic busy);
        if (absent)
            return RSP_ABSENT;
        else if (busy)
            return RSP_WAIT;
        else
            return RSP_TAKE;
    endfunction

    // The instruction goes forward only if it is valid, passes its
    // condition and is not in a branch shadow.
    function automatic logic offered(input hs_issue_t iss);
        return iss.valid && iss.cond_ok && !iss.shadow;
    endfunction

    // During a transfer, both lines high means "last word".
    function automatic logic xfer_end(input logic absent, input logic busy);
        return absent && busy;
    endfunction

endpackage

// File: rtl/cop_hs_addr_gen.sv
module cop_hs_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int MAX_WORDS  = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              last_word
);
    localparam int CNT_W = $clog2(MAX_WORDS) + 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_WORDS - 1);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= start_addr;
            cnt_q  <= '0;
        end else if (step) begin
            addr_q <= addr_q + STRIDE;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign addr      = addr_q;
    assign last_word = (cnt_q == LAST_IDX);

endmodule

// File: rtl/cop_hs_fsm.sv
module cop_hs_fsm
    import cop_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hs_issue_t issue,
    input  logic      is_xfer,
    input  logic      irq,
    input  logic      cop_absent,
    input  logic      cop_busy,
    input  logic      last_word,
    output hs_state_e state,
    output logic      accept,
    output logic      irq_pulse
);
    hs_state_e state_q, state_d;
    logic      xfer_q;
    logic      irq_q, irq_d;
    hs_resp_e  resp;

    assign resp   = classify(cop_absent, cop_busy);
    assign accept = (state_q == ST_IDLE) && offered(issue);

    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                unique case (resp)
                    RSP_ABSENT: state_d = ST_TRAP;
                    RSP_WAIT:   state_d = ST_BUSY_WAIT;
                    default:    state_d = xfer_q ? ST_XFER : ST_DONE;
                endcase
            end
            ST_BUSY_WAIT: begin
                unique case (resp)
                    RSP_ABSENT: state_d = ST_TRAP;
                    RSP_TAKE:   state_d = xfer_q ? ST_XFER : ST_DONE;
                    default: begin
                        if (irq) begin
                            state_d = ST_IDLE;
                            irq_d   = 1'b1;
                        end
                    end
                endcase
            end
            ST_XFER: begin
                if (xfer_end(cop_absent, cop_busy) || last_word)
                    state_d = ST_DONE;
            end
            ST_TRAP: state_d = ST_IDLE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            xfer_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
            if (accept)
                xfer_q <= is_xfer;
        end
    end

    assign state     = state_q;
    assign irq_pulse = irq_q;

endmodule

// File: rtl/cop_handshake_ctrl.sv
module cop_handshake_ctrl
    import cop_hs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_WORDS  = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic              is_xfer,
    input  logic              cond_pass,
    input  logic              in_shadow,
    input  logic              irq,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              cop_absent,
    input  logic              cop_busy,
    output logic              cop_req,
    output logic              stall,
    output logic              undef_trap,
    output logic              irq_take,
    output logic              retire,
    output logic              xfer_active,
    output logic [ADDR_W-1:0] addr
);
    hs_issue_t issue;
    hs_state_e state;
    logic      accept;
    logic      last_word;
    logic      irq_pulse;

    assign issue = '{valid: instr_valid, cond_ok: cond_pass, shadow: in_shadow};

    cop_hs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .is_xfer    (is_xfer),
        .irq        (irq),
        .cop_absent (cop_absent),
        .cop_busy   (cop_busy),
        .last_word  (last_word),
        .state      (state),
        .accept     (accept),
        .irq_pulse  (irq_pulse)
    );

    cop_hs_addr_gen #(
        .ADDR_W     (ADDR_W),
        .MAX_WORDS  (MAX_WORDS),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .step       (state == ST_XFER),
        .start_addr (start_addr),
        .addr       (addr),
        .last_word  (last_word)
    );

    assign cop_req     = (state == ST_DECIDE) || (state == ST_BUSY_WAIT);
    assign stall       = (state == ST_BUSY_WAIT);
    assign undef_trap  = (state == ST_TRAP);
    assign retire      = (state == ST_DONE);
    assign xfer_active = (state == ST_XFER);
    assign irq_take    = irq_pulse;

endmodule

// File: rtl/cop_hs_checker.sv
module cop_hs_checker #(
    parameter int ADDR_W     = 32,
    parameter int MAX_WORDS  = 16,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic              cond_pass,
    input logic              in_shadow,
    input logic              irq,
    input logic              cop_absent,
    input logic              cop_busy,
    input logic              cop_req,
    input logic              stall,
    input logic              undef_trap,
    input logic              irq_take,
    input logic              retire,
    input logic              xfer_active,
    input logic [ADDR_W-1:0] addr
);
    localparam int RUN_W = $clog2(MAX_WORDS) + 2;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !xfer_active)
            run_q <= '0;
        else
            run_q <= run_q + 1'b1;
    end

    assert_drop_no_req_R2: assert property (@(posedge clk) disable iff (rst)
        (!cop_req && instr_valid && (!cond_pass || in_shadow)) |=> !cop_req);

    assert_absent_traps_R4: assert property (@(posedge clk) disable iff (rst)
        (cop_req && cop_absent) |=> (undef_trap && !cop_req));

    assert_trap_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        undef_trap |=> !undef_trap);

    assert_busy_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        (cop_req && !cop_absent && cop_busy && !irq) |=> stall);

    assert_take_commits_R6: assert property (@(posedge clk) disable iff (rst)
        (cop_req && !cop_absent && !cop_busy) |=> (retire || xfer_active));

    assert_irq_abandons_R7: assert property (@(posedge clk) disable iff (rst)
        (stall && !cop_absent && cop_busy && irq) |=> (irq_take && !cop_req && !retire));

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take);

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && $past(xfer_active)) |-> (addr == $past(addr) + ADDR_W'(WORD_BYTES)));

    assert_end_retires_R9: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && cop_absent && cop_busy) |=> (retire && !xfer_active));

    assert_word_cap_R10: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(MAX_WORDS));

    assert_xfer_no_irq_R11: assert property (@(posedge clk) disable iff (rst)
        xfer_active |-> !irq_take);

    assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cop_req, undef_trap, irq_take, retire, xfer_active}));

endmodule

bind cop_handshake_ctrl cop_hs_checker #(
    .ADDR_W     (ADDR_W),
    .MAX_WORDS  (MAX_WORDS),
    .WORD_BYTES (WORD_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .cond_pass   (cond_pass),
    .in_shadow   (in_shadow),
    .irq         (irq),
    .cop_absent  (cop_absent),
    .cop_busy    (cop_busy),
    .cop_req     (cop_req),
    .stall       (stall),
    .undef_trap  (undef_trap),
    .irq_take    (irq_take),
    .retire      (retire),
    .xfer_active (xfer_active),
    .addr        (addr)
);

// File: tb/cop_handshake_ctrl_test.sv
module cop_handshake_ctrl_test;
    localparam int ADDR_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic instr_valid = 1'b0, is_xfer = 1'b0, cond_pass = 1'b0, in_shadow = 1'b0;
    logic irq = 1'b0, cop_absent = 1'b0, cop_busy = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic cop_req, stall, undef_trap, irq_take, retire, xfer_active;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cop_handshake_ctrl uut (
        .clk (clk), .rst (rst), .instr_valid (instr_valid), .is_xfer (is_xfer),
        .cond_pass (cond_pass), .in_shadow (in_shadow), .irq (irq),
        .start_addr (start_addr), .cop_absent (cop_absent), .cop_busy (cop_busy),
        .cop_req (cop_req), .stall (stall), .undef_trap (undef_trap),
        .irq_take (irq_take), .retire (retire), .xfer_active (xfer_active),
        .addr (addr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Vector fields: cond, shadow, absent, busy_n[2:0], exp_trap, exp_retire,
    //                exp_stall[2:0], exp_req[2:0]
    localparam int NV = 7;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0},  // R2 cond fail
        {1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0},  // R2 shadow
        {1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 3'd0},  // R2 both
        {1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 3'd0, 3'd1},  // R4 absent
        {1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 3'd1},  // R6 immediate
        {1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 3'd1, 3'd2},  // R5 one wait
        {1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 3'd4, 3'd5}   // R5 four waits
    };

    task automatic issue(input logic c, input logic s, input logic x, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        instr_valid = 1'b1; cond_pass = c; in_shadow = s; is_xfer = x; start_addr = a;
        cop_absent = 1'b0; cop_busy = 1'b0;
    endtask

    // Runs a transfer; coprocessor ends it after end_n words (0 = never).
    task automatic run_xfer(input logic [ADDR_W-1:0] base, input int end_n,
                            input logic hold_irq, input int exp_words, input string req);
        int words = 0;
        int rets = 0;
        int irqs = 0;
        int bad_addr = 0;
        issue(1'b1, 1'b0, 1'b1, base);
        irq = hold_irq;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
            if (xfer_active) begin
                if (addr != base + ADDR_W'(4 * words)) bad_addr++;
                words++;
            end
            if (retire) rets++;
            if (irq_take) irqs++;
            cop_absent = xfer_active && (end_n != 0) && (words == end_n);
            cop_busy   = cop_absent;
        end
        irq = 1'b0; cop_absent = 1'b0; cop_busy = 1'b0;
        chk(words == exp_words, {req, " word count"}, words, exp_words);
        chk(bad_addr == 0, "R8 address sequence", bad_addr, 0);
        chk(rets == 1, {req, " retire after transfer"}, rets, 1);
        if (hold_irq) chk(irqs == 0, "R11 irq ignored in transfer", irqs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset held
        chk({cop_req, stall, undef_trap, irq_take, retire, xfer_active} == 6'b0,
            "R1 outputs in reset", {cop_req, stall, undef_trap, irq_take, retire, xfer_active}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({cop_req, stall, undef_trap, irq_take, retire, xfer_active} == 6'b0,
            "R1 outputs after reset", {cop_req, stall, undef_trap, irq_take, retire, xfer_active}, 0);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [13:0] e = VEC[v];
            int served = 0, nreq = 0, nstall = 0, ntrap = 0, nret = 0;
            issue(e[13], e[12], 1'b0, '0);
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                instr_valid = 1'b0;
                if (cop_req) nreq++;
                if (stall) nstall++;
                if (undef_trap) ntrap++;
                if (retire) nret++;
                if (cop_req) begin
                    cop_absent = e[11];
                    cop_busy   = (served < int'(e[10:8]));
                    served++;
                end else begin
                    cop_absent = 1'b0; cop_busy = 1'b0;
                end
            end
            cop_absent = 1'b0; cop_busy = 1'b0;
            chk(nreq == int'(e[2:0]), "R3 request cycles", nreq, e[2:0]);
            chk(nstall == int'(e[5:3]), "R5 stall cycles", nstall, e[5:3]);
            chk(ntrap == int'(e[7]), "R4 trap pulses", ntrap, e[7]);
            chk(nret == int'(e[6]), "R6 retire pulses", nret, e[6]);
        end

        // R7: interrupt during busy-wait
        begin
            int nret = 0, nirq = 0;
            issue(1'b1, 1'b0, 1'b0, '0);
            @(negedge clk); instr_valid = 1'b0; cop_busy = 1'b1;  // DECIDE
            @(negedge clk);                                        // BUSY_WAIT 1
            chk(stall == 1'b1, "R5 stall entered", stall, 1);
            @(negedge clk); irq = 1'b1;                            // BUSY_WAIT 2
            @(negedge clk); irq = 1'b0;
            chk(irq_take == 1'b1, "R7 irq_take pulse", irq_take, 1);
            chk(cop_req == 1'b0 && stall == 1'b0, "R7 request dropped", {cop_req, stall}, 0);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (retire) nret++;
                if (irq_take) nirq++;
            end
            cop_busy = 1'b0;
            chk(nret == 0, "R7 no retire after abandon", nret, 0);
            chk(nirq == 0, "R7 single pulse", nirq, 0);
        end

        // R8 R9: coprocessor ends after 3 words
        run_xfer(32'h0000_1000, 3, 1'b0, 3, "R9");
        // R10 R11: no end signal, irq held high, cap at 16
        run_xfer(32'h0000_2040, 0, 1'b1, 16, "R10");
        // R9: end signal on first word
        run_xfer(32'hFFFF_FFF8, 1, 1'b0, 1, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule